// File: doc/BRIEF.md
# Fixed-Latency Iterative Integer Divider

This unit divides one integer operand by another for a processor execution pipeline. A request is a single-cycle `start_i` pulse carrying a dividend, a divisor and three control bits. The bits choose signed or unsigned arithmetic, full-width or half-width operands, and whether the quotient or the remainder is returned. The unit then works through a restoring shift-subtract loop that produces one quotient bit per clock. It always runs `XLEN` iterations, even when the operands are half width. After that it raises `done_o` for one cycle, with the result on `result_o`.

Signed requests divide the operand magnitudes and fix the signs afterwards. The quotient is negated when the operand signs differ. The remainder takes the sign of the dividend. A zero divisor gives a result of zero with normal timing. The signed overflow case (most negative value divided by minus one) wraps without any trap. The unit uses the same start/completion handshake as a multiplier. It holds one division at a time, and `busy_o` marks when it cannot take a new one.

The controller has three states:
- `ST_IDLE`: waiting for a request. `start_i` moves it to `ST_RUN` and loads the operands.
- `ST_RUN`: performs one iteration per cycle. After the `XLEN`-th iteration it moves to `ST_DONE`.
- `ST_DONE`: presents the result for one cycle, then returns unconditionally to `ST_IDLE`.

Top module: `div_iter_unit`

## Requirements
- R1: After reset `busy_o`, `done_o` and `result_o` are all low.
- R2: When `start_i` is high while `busy_o` is low, the request is accepted. `busy_o` is high from the next cycle until the `done_o` cycle, both included.
- R3: `done_o` is high for exactly one cycle. That cycle comes exactly `XLEN` clock edges after the accepting edge, for both full-width and half-width requests.
- R4: When `is_signed_i` is 0 and `is_word_i` is 0, the result is the unsigned `XLEN`-bit quotient (`want_rem_i` = 0) or remainder (`want_rem_i` = 1).
- R5: When `is_signed_i` is 1, operands are two's complement. The quotient truncates toward zero, and a nonzero remainder has the sign of the dividend.
- R6: When `is_word_i` is 1, only the low `HALF` bits of each operand are used, and the upper bits are ignored. The `HALF`-bit result is sign-extended (signed) or zero-extended (unsigned) to `XLEN` bits.
- R7: A zero divisor, in the selected width, gives `result_o` = 0 for both the quotient and the remainder. `done_o` comes at the normal time.
- R8: In the selected width, a signed division of the most negative value by -1 gives the most negative value as the quotient and 0 as the remainder. In half width the quotient is then sign-extended.
- R9: A `start_i` pulse while `busy_o` is high is ignored. This holds in `ST_RUN` and in the `ST_DONE` cycle. The running division's result and timing are unchanged, and any change of the operand or control inputs during the run has no effect.
- R10: `result_o` is zero in every cycle in which `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled when not busy |
| dividend_i | input | XLEN | Dividend |
| divisor_i | input | XLEN | Divisor |
| is_signed_i | input | 1 | 1 = two's complement operands |
| is_word_i | input | 1 | 1 = half-width operation on the low HALF bits |
| want_rem_i | input | 1 | 1 = return the remainder, 0 = return the quotient |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | XLEN | Result, valid while done_o is high, otherwise zero |

## Verification
A small instance (`XLEN` = 8, `HALF` = 4) is swept across every half-width operand pair, with junk in the ignored upper bits, for all four signedness and quotient/remainder combinations. Full-width requests are swept over a strided grid that covers zero, one, minus one, both extremes and values near the sign boundary. This separates magnitude errors, sign-correction errors and extension errors. A default 64-bit instance takes a handful of directed operands (wrap-around overflow, zero divisor, maximum unsigned value, half width with garbage upper bits) and confirms the 64-edge latency. Injected start pulses during `ST_RUN`, together with operand changes, and a pulse in the `ST_DONE` cycle show that a running division cannot be disturbed.

// File: rtl/div_iter_pkg.sv
package div_iter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } div_state_e;

    typedef struct packed {
        logic is_signed;
        logic is_word;
        logic want_rem;
    } div_ctrl_t;

endpackage

// File: rtl/div_operand_prep.sv
// Extends an operand to the working width and splits it into sign and magnitude.
module div_operand_prep #(
    parameter int XLEN = 64,
    parameter int HALF = 32
) (
    input  logic [XLEN-1:0] value_i,
    input  logic            is_signed_i,
    input  logic            is_word_i,
    output logic [XLEN-1:0] mag_o,
    output logic            neg_o,
    output logic            zero_o
);
    localparam int UPPER = XLEN - HALF;

    logic [XLEN-1:0] widened;

    generate
        if (HALF < XLEN) begin : g_word
            always_comb begin
                widened = value_i;
                if (is_word_i) begin
                    if (is_signed_i)
                        widened = {{UPPER{value_i[HALF-1]}}, value_i[HALF-1:0]};
                    else
                        widened = {{UPPER{1'b0}}, value_i[HALF-1:0]};
                end
            end
        end else begin : g_full
            logic unused_word;
            assign unused_word = is_word_i;
            assign widened     = value_i;
        end
    endgenerate

    assign neg_o  = is_signed_i & widened[XLEN-1];
    assign mag_o  = neg_o ? (-widened) : widened;
    assign zero_o = (widened == '0);
endmodule

// File: rtl/div_restore_step.sv
// One restoring iteration: shift the partial remainder left and subtract the divisor when it fits.
module div_restore_step #(
    parameter int XLEN = 64
) (
    input  logic [2*XLEN-1:0] rem_i,
    input  logic [XLEN-1:0]   dvs_i,
    output logic [2*XLEN-1:0] rem_o
);
    logic [XLEN:0]   top;
    logic [XLEN+1:0] diff;
    logic            fits;
    logic            unused_diff;

    assign top         = rem_i[2*XLEN-1:XLEN-1];
    assign diff        = {1'b0, top} - {2'b00, dvs_i};
    assign fits        = ~diff[XLEN+1];
    assign unused_diff = diff[XLEN];

    always_comb begin
        rem_o[XLEN-1:0] = {rem_i[XLEN-2:0], fits};
        if (fits)
            rem_o[2*XLEN-1:XLEN] = diff[XLEN-1:0];
        else
            rem_o[2*XLEN-1:XLEN] = top[XLEN-1:0];
    end
endmodule

// File: rtl/div_result_fix.sv
// Sign correction, quotient/remainder select, half-width extension, zero-divisor override.
module div_result_fix
    import div_iter_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int HALF = 32
) (
    input  logic [2*XLEN-1:0] rem_i,
    input  div_ctrl_t         ctrl_i,
    input  logic              neg_quo_i,
    input  logic              neg_rem_i,
    input  logic              div0_i,
    output logic [XLEN-1:0]   result_o
);
    localparam int UPPER = XLEN - HALF;

    logic [XLEN-1:0] quo_mag, rmd_mag, quo_s, rmd_s, picked, widened;

    assign quo_mag = rem_i[XLEN-1:0];
    assign rmd_mag = rem_i[2*XLEN-1:XLEN];
    assign quo_s   = neg_quo_i ? (-quo_mag) : quo_mag;
    assign rmd_s   = neg_rem_i ? (-rmd_mag) : rmd_mag;
    assign picked  = ctrl_i.want_rem ? rmd_s : quo_s;

    generate
        if (HALF < XLEN) begin : g_word
            always_comb begin
                widened = picked;
                if (ctrl_i.is_word) begin
                    if (ctrl_i.is_signed)
                        widened = {{UPPER{picked[HALF-1]}}, picked[HALF-1:0]};
                    else
                        widened = {{UPPER{1'b0}}, picked[HALF-1:0]};
                end
            end
        end else begin : g_full
            assign widened = picked;
        end
    endgenerate

    assign result_o = div0_i ? '0 : widened;
endmodule

// File: rtl/div_iter_unit.sv
// Fixed-latency iterative divider: IDLE -> RUN (XLEN steps) -> DONE -> IDLE.
module div_iter_unit
    import div_iter_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int HALF = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] dividend_i,
    input  logic [XLEN-1:0] divisor_i,
    input  logic            is_signed_i,
    input  logic            is_word_i,
    input  logic            want_rem_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);
    localparam int          RW   = 2 * XLEN;
    localparam int          CW   = (XLEN > 1) ? $clog2(XLEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(XLEN - 1);
    localparam int          LW   = $clog2(XLEN + 2) + 1;

    div_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [RW-1:0]   rem_q, rem_step;
    logic [XLEN-1:0] dvs_q;
    div_ctrl_t       ctrl_q;
    logic            neg_quo_q, neg_rem_q, div0_q;
    logic            accept;

    logic [XLEN-1:0] a_mag, b_mag, fixed_res;
    logic            a_neg, b_neg, a_zero, b_zero;
    logic            unused_a_zero;

    assign accept        = start_i && (state_q == ST_IDLE);
    assign unused_a_zero = a_zero;

    div_operand_prep #(.XLEN(XLEN), .HALF(HALF)) u_prep_a (
        .value_i(dividend_i), .is_signed_i(is_signed_i), .is_word_i(is_word_i),
        .mag_o(a_mag), .neg_o(a_neg), .zero_o(a_zero)
    );

    div_operand_prep #(.XLEN(XLEN), .HALF(HALF)) u_prep_b (
        .value_i(divisor_i), .is_signed_i(is_signed_i), .is_word_i(is_word_i),
        .mag_o(b_mag), .neg_o(b_neg), .zero_o(b_zero)
    );

    div_restore_step #(.XLEN(XLEN)) u_step (
        .rem_i(rem_q), .dvs_i(dvs_q), .rem_o(rem_step)
    );

    div_result_fix #(.XLEN(XLEN), .HALF(HALF)) u_fix (
        .rem_i(rem_q), .ctrl_i(ctrl_q), .neg_quo_i(neg_quo_q),
        .neg_rem_i(neg_rem_q), .div0_i(div0_q), .result_o(fixed_res)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            rem_q     <= '0;
            dvs_q     <= '0;
            ctrl_q    <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            div0_q    <= 1'b0;
        end else if (accept) begin
            cnt_q     <= '0;
            rem_q     <= {{XLEN{1'b0}}, a_mag};
            dvs_q     <= b_mag;
            ctrl_q    <= '{is_signed: is_signed_i, is_word: is_word_i, want_rem: want_rem_i};
            neg_quo_q <= a_neg ^ b_neg;
            neg_rem_q <= a_neg;
            div0_q    <= b_zero;
        end else if (state_q == ST_RUN) begin
            cnt_q <= cnt_q + CW'(1);
            rem_q <= rem_step;
        end
    end

    // Outputs
    always_comb begin
        busy_o   = 1'b0;
        done_o   = 1'b0;
        result_o = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  busy_o = 1'b1;
            ST_DONE: begin
                busy_o   = 1'b1;
                done_o   = 1'b1;
                result_o = fixed_res;
            end
            default: ;
        endcase
    end

    // Checker state: edges since the accepting edge, and whether the captured divisor was zero
    logic [LW-1:0] chk_lat;
    logic          chk_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_lat  <= '0;
            chk_zero <= 1'b0;
        end else if (start_i && !busy_o) begin
            chk_lat  <= '0;
            chk_zero <= is_word_i ? (divisor_i[HALF-1:0] == '0) : (divisor_i == '0);
        end else if (busy_o) begin
            chk_lat <= chk_lat + LW'(1);
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (chk_lat == LW'(XLEN))); // R3
    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && chk_zero) |-> (result_o == '0)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o); // R9
endmodule

// File: tb/tb_div_iter_unit.sv
`timescale 1ns/1ps
module tb_div_iter_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [63:0] op_a = '0, op_b = '0;
    logic        sgn = 1'b0, wrd = 1'b0, rm = 1'b0;
    logic        st8 = 1'b0, st64 = 1'b0;
    logic        busy8, done8, busy64, done64;
    logic [7:0]  res8;
    logic [63:0] res64;

    int n_checks = 0;
    int n_fail   = 0;

    div_iter_unit #(.XLEN(8), .HALF(4)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(st8),
        .dividend_i(op_a[7:0]), .divisor_i(op_b[7:0]),
        .is_signed_i(sgn), .is_word_i(wrd), .want_rem_i(rm),
        .busy_o(busy8), .done_o(done8), .result_o(res8)
    );

    div_iter_unit dut64 (
        .clk(clk), .rst_n(rst_n), .start_i(st64),
        .dividend_i(op_a), .divisor_i(op_b),
        .is_signed_i(sgn), .is_word_i(wrd), .want_rem_i(rm),
        .busy_o(busy64), .done_o(done64), .result_o(res64)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mask_of(input int w);
        return (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] extend(input logic [63:0] v, input int w, input bit s);
        logic [63:0] m = mask_of(w);
        logic [63:0] r = v & m;
        if (s && r[w-1]) r = r | ~m;
        return r;
    endfunction

    // Arithmetic reference model for R4..R8
    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input bit s, input bit word, input bit rem, input int xl);
        int          w  = word ? xl / 2 : xl;
        logic [63:0] ea = extend(a, w, s);
        logic [63:0] eb = extend(b, w, s);
        logic [63:0] q, r, minv;
        minv = extend(64'd1 << (w - 1), w, 1'b1);
        if (eb == 64'd0) return 64'd0;
        if (s) begin
            if (ea == minv && eb == {64{1'b1}}) begin
                q = minv; r = 64'd0;
            end else begin
                q = 64'($signed(ea) / $signed(eb));
                r = 64'($signed(ea) % $signed(eb));
            end
        end else begin
            q = ea / eb;
            r = ea % eb;
        end
        return extend(rem ? r : q, w, s) & mask_of(xl);
    endfunction

    // Runs one request; inj > 0 drives a disturbing start pulse at that cycle (R9);
    // poke_done drives a start pulse in the done cycle and checks it is ignored (R9).
    task automatic run_op(input bit big, input logic [63:0] a, input logic [63:0] b,
                          input bit s, input bit word, input bit rem,
                          input int inj, input bit poke_done, input string tag);
        int          xl  = big ? 64 : 8;
        logic [63:0] exp = model(a, b, s, word, rem, xl);
        logic [63:0] act;
        int          cyc = 0;
        bit          seen = 1'b0;
        @(negedge clk);
        op_a = a; op_b = b; sgn = s; wrd = word; rm = rem;
        if (big) st64 = 1'b1; else st8 = 1'b1;
        @(negedge clk);
        st8 = 1'b0; st64 = 1'b0;
        cyc = 1;
        check((big ? busy64 : busy8) == 1'b1, "R2 busy after accept", 64'(big ? busy64 : busy8), 64'd1);
        while (cyc < 200) begin
            if (big ? done64 : done8) begin
                seen = 1'b1;
                break;
            end
            check((big ? res64 : 64'(res8)) == 64'd0, "R10 result zero while not done",
                  big ? res64 : 64'(res8), 64'd0);
            if (cyc == inj) begin
                op_a = ~a; op_b = b + 64'd1; sgn = ~s; wrd = ~word; rm = ~rem;
                if (big) st64 = 1'b1; else st8 = 1'b1;
            end else if (cyc == inj + 1) begin
                st8 = 1'b0; st64 = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        st8 = 1'b0; st64 = 1'b0;
        check(seen, "R3 done never seen (watchdog)", 64'(cyc), 64'(xl + 1));
        // done is visible after the XLEN-th edge following the accepting edge
        check(cyc - 1 == xl, "R3 latency", 64'(cyc - 1), 64'(xl));
        act = big ? res64 : 64'(res8);
        check(act == exp, tag, act, exp);
        if (poke_done) begin
            if (big) st64 = 1'b1; else st8 = 1'b1;
        end
        @(negedge clk);
        st8 = 1'b0; st64 = 1'b0;
        check((big ? done64 : done8) == 1'b0, "R3 done single cycle", 64'(big ? done64 : done8), 64'd0);
        if (poke_done)
            check((big ? busy64 : busy8) == 1'b0, "R9 start in done cycle ignored",
                  64'(big ? busy64 : busy8), 64'd0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy8 == 1'b0 && done8 == 1'b0 && res8 == 8'd0, "R1 reset small", 64'(res8), 64'd0);
        check(busy64 == 1'b0 && done64 == 1'b0 && res64 == 64'd0, "R1 reset wide", res64, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy8 == 1'b0 && done8 == 1'b0, "R1 idle after reset", 64'(busy8), 64'd0);

        // R6 sweep: every half-width pair, junk in upper bits, all flag combinations (R5, R7, R8)
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int f = 0; f < 4; f++) begin
                    run_op(1'b0, 64'((a + 16 * ((a + b) % 16)) & 255), 64'((b + 16 * (15 - a)) & 255),
                           f[0], 1'b1, f[1], 0, 1'b0, "R6 half-width result");
                end
            end
        end

        // R4/R5 full-width sweep, strided grid with boundary values (R7, R8)
        for (int a = 0; a < 256; a++) begin
            if (a % 5 == 0 || a >= 250 || (a >= 125 && a <= 130) || a == 1) begin
                for (int bi = 0; bi < 33; bi++) begin
                    int b = (bi < 29) ? bi * 9 : (bi == 29 ? 255 : (bi == 30 ? 128 : (bi == 31 ? 127 : 1)));
                    for (int f = 0; f < 4; f++) begin
                        run_op(1'b0, 64'(a), 64'(b), f[0], 1'b0, f[1], 0, 1'b0,
                               f[0] ? "R5 signed full-width" : "R4 unsigned full-width");
                    end
                end
            end
        end

        // R8 explicit overflow, R7 explicit zero divisor (small)
        run_op(1'b0, 64'h80, 64'hFF, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R8 overflow quotient");
        run_op(1'b0, 64'h80, 64'hFF, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R8 overflow remainder");
        run_op(1'b0, 64'h98, 64'hAF, 1'b1, 1'b1, 1'b0, 0, 1'b0, "R8 half-width overflow");
        run_op(1'b0, 64'h5B, 64'h00, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R7 zero divisor");

        // R9: disturbing starts during RUN, and in the DONE cycle
        run_op(1'b0, 64'hC8, 64'h07, 1'b1, 1'b0, 1'b0, 3, 1'b0, "R9 start during run ignored");
        run_op(1'b0, 64'h64, 64'h0B, 1'b0, 1'b0, 1'b1, 8, 1'b1, "R9 late start ignored");

        // Default-width instance: 64-edge latency in both widths (R3)
        run_op(1'b1, 64'd1000000007, 64'd97, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R4 wide quotient");
        run_op(1'b1, 64'd1000000007, 64'd97, 1'b0, 1'b0, 1'b1, 0, 1'b0, "R4 wide remainder");
        run_op(1'b1, {64{1'b1}}, 64'd3, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R4 wide max unsigned");
        run_op(1'b1, -64'sd100, 64'd7, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R5 wide signed quotient");
        run_op(1'b1, -64'sd100, 64'd7, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R5 wide signed remainder");
        run_op(1'b1, 64'h8000_0000_0000_0000, {64{1'b1}}, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R8 wide overflow");
        run_op(1'b1, 64'hDEAD_BEEF_8000_0000, 64'h1234_5678_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 0, 1'b0,
               "R8 wide half overflow");
        run_op(1'b1, 64'hDEAD_BEEF_FFFF_FF9C, 64'hCAFE_0000_0000_0007, 1'b0, 1'b1, 1'b0, 0, 1'b0,
               "R6 wide half unsigned");
        run_op(1'b1, 64'hDEAD_BEEF_FFFF_FF9C, 64'hCAFE_0000_0000_0007, 1'b1, 1'b1, 1'b1, 0, 1'b0,
               "R6 wide half signed remainder");
        run_op(1'b1, 64'd12345, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, 1'b0, 0, 1'b0, "R7 wide half zero divisor");
        run_op(1'b1, 64'd12345, 64'd0, 1'b1, 1'b0, 1'b1, 20, 1'b1, "R7 wide zero divisor with R9 pokes");

        finish_run();
    end
endmodule